// File: doc/BRIEF.md
# DMA Channel Completion Status Controller

This block keeps the completion and fault state of one DMA channel and decides whether the channel may move to its next descriptor. A simplified descriptor engine sends it event signals: the byte count has reached zero, the peripheral reports it is done, the descriptor carries an interrupt-on-done mark, a descriptor or buffer pointer is bad, or an abort is requested. From these events the block sets pending flags. Software clears those flags by writing 1 to them. The block drives one interrupt line, a stall level, a retry pulse and an advance pulse back to the engine.

A fault freezes the channel. The remaining byte count at the moment of the fault is captured. The stall holds until software clears the fault flag. When the flag clears, the block pulses retry and presents the captured count, so the engine resumes the same descriptor where it stopped. An abort does not resume the descriptor: it skips to the next one. All engine outputs are registered and change on the clock edge after the input cycle that causes them.

Top module: `dma_cmpl_stat`

## Requirements
- R1: After reset, every pending flag and every enable is 0. The read word, `irq`, `ch_stall`, `ch_retry`, `ch_advance` and `resume_cnt` are also 0.
- R2: A register write loads the enables from write-data bits 25 (normal), 24 (fault), 23 (abort) and 22 (premature). In the same write, a 1 at a pending position (31 normal, 30 fault, 28 abort, 27 premature) clears that flag and a 0 leaves it unchanged. The read word shows the flags and enables at those positions, `resume_cnt` in bits [CNT_W-1:0], and 0 in every other bit.
- R3: If a flag is set by an event and cleared by a write in the same cycle, the flag ends up set.
- R4: `irq` is 1 exactly when at least one pending flag is 1 and its enable is also 1.
- R5: A normal completion is `cnt_zero` or `periph_done`. It sets the normal flag (bit 31) only if the normal enable or `desc_irq_done` is 1. It always produces a one-cycle `ch_advance` on the next cycle.
- R6: A normal completion in which `periph_done` is 1, `cnt_zero` is 0 and `remaining_cnt` is nonzero also sets the premature flag (bit 27).
- R7: `bad_desc_ptr` or `bad_buf_ptr` sets the fault flag (bit 30) and raises `ch_stall`. It also copies `remaining_cnt` into `resume_cnt`, and it causes no advance.
- R8: While `ch_stall` is 1, every engine event is ignored. No flag is set, `ch_advance` stays 0 and `resume_cnt` holds its value.
- R9: When software clears the fault flag, `ch_stall` falls. In that same cycle `ch_retry` is 1 for exactly one cycle, and `resume_cnt` keeps the captured count.
- R10: `abort_req` sets the abort flag (bit 28) and produces a one-cycle `ch_advance`. It does not set the normal or premature flag.
- R11: When several events arrive in one cycle, a fault takes priority over an abort, and an abort takes priority over a normal completion. Only the winning event takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read word |
| cnt_zero | input | 1 | Descriptor byte count reached zero |
| periph_done | input | 1 | Peripheral signals completion |
| desc_irq_done | input | 1 | Current descriptor requests an interrupt on done |
| bad_desc_ptr | input | 1 | Descriptor pointer fault |
| bad_buf_ptr | input | 1 | Data buffer pointer fault |
| abort_req | input | 1 | Abandon current descriptor |
| remaining_cnt | input | CNT_W | Bytes left in the current descriptor |
| irq | output | 1 | Interrupt request |
| ch_stall | output | 1 | Channel frozen by a fault |
| ch_retry | output | 1 | One-cycle pulse: resume the same descriptor |
| ch_advance | output | 1 | One-cycle pulse: move to the next descriptor |
| resume_cnt | output | CNT_W | Byte count captured at the last fault |

## Verification
The bench targets events that arrive in the same cycle as other events or writes:
- A write that clears a flag in the cycle its event fires must leave the flag set. A design that let the clear win would lose that interrupt.
- Completions, aborts and new faults that arrive during a stall must change nothing. A design that advanced or re-captured here would skip a descriptor or corrupt the saved count.
- Several events at once must resolve by priority. Getting this wrong would show as an advance alongside a fault, or as a normal flag set together with an abort.

The bench also checks that the retry pulse lands exactly on the cycle the stall falls. It checks that a premature completion is told apart from a count that simply reached zero.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;

  // Flag order used across the block: 0 normal, 1 fault, 2 abort, 3 premature
  localparam int NFLAG   = 4;
  localparam int F_NORM  = 0;
  localparam int F_FAULT = 1;
  localparam int F_ABORT = 2;
  localparam int F_PREM  = 3;
  localparam int EN_TOP  = 25;

  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_FAULT = 2'd1,
    EV_ABORT = 2'd2,
    EV_DONE  = 2'd3
  } ev_kind_t;

  // Register bit where a pending flag lives
  function automatic int pend_pos(input int idx);
    case (idx)
      F_NORM:  return 31;
      F_FAULT: return 30;
      F_ABORT: return 28;
      default: return 27;
    endcase
  endfunction

  // Register bit where an enable lives
  function automatic int en_pos(input int idx);
    return EN_TOP - idx;
  endfunction

  // Priority: fault over abort over completion; nothing while stalled
  function automatic ev_kind_t classify(input logic stalled, input logic fault,
                                        input logic abort, input logic done);
    if (stalled)    return EV_IDLE;
    else if (fault) return EV_FAULT;
    else if (abort) return EV_ABORT;
    else if (done)  return EV_DONE;
    else            return EV_IDLE;
  endfunction

  function automatic logic norm_flag_wanted(input logic en, input logic desc_mark);
    return en | desc_mark;
  endfunction

  function automatic logic is_premature(input logic periph_done, input logic cnt_zero,
                                        input logic cnt_left);
    return periph_done & ~cnt_zero & cnt_left;
  endfunction

endpackage

// File: rtl/dma_cs_evt.sv
module dma_cs_evt
  import dma_cs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stalled,
  input  logic              norm_en,
  input  logic              cnt_zero,
  input  logic              periph_done,
  input  logic              desc_irq_done,
  input  logic              bad_desc_ptr,
  input  logic              bad_buf_ptr,
  input  logic              abort_req,
  input  logic [CNT_W-1:0]  remaining_cnt,
  output logic              take_fault,
  output logic              take_abort,
  output logic              take_done,
  output logic [NFLAG-1:0]  flag_set
);

  logic     any_fault;
  logic     any_done;
  ev_kind_t ev_kind;

  assign any_fault = bad_desc_ptr | bad_buf_ptr;
  assign any_done  = cnt_zero | periph_done;
  assign ev_kind   = classify(stalled, any_fault, abort_req, any_done);

  assign take_fault = (ev_kind == EV_FAULT);
  assign take_abort = (ev_kind == EV_ABORT);
  assign take_done  = (ev_kind == EV_DONE);

  always_comb begin
    flag_set          = '0;
    flag_set[F_NORM]  = take_done & norm_flag_wanted(norm_en, desc_irq_done);
    flag_set[F_FAULT] = take_fault;
    flag_set[F_ABORT] = take_abort;
    flag_set[F_PREM]  = take_done & is_premature(periph_done, cnt_zero, |remaining_cnt);
  end

  // R11: at most one event class is taken per cycle
  assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_fault, take_abort, take_done}));

  // R8: nothing is taken while the channel is stalled
  assert_quiet_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (flag_set == '0));

endmodule

// File: rtl/dma_cs_flags.sv
module dma_cs_flags
  import dma_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  flag_set,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [NFLAG-1:0]  pend,
  output logic [NFLAG-1:0]  en,
  output logic              irq
);

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    localparam int PP = pend_pos(gi);
    localparam int EP = en_pos(gi);
    logic clr;

    assign clr = reg_wr & reg_wdata[PP];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[gi] <= 1'b0;
        en[gi]   <= 1'b0;
      end else begin
        pend[gi] <= (pend[gi] & ~clr) | flag_set[gi];
        if (reg_wr) en[gi] <= reg_wdata[EP];
      end
    end

    // R2: a flag survives any cycle without a matching write-1
    assert_w1c_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[gi] && !(reg_wr && reg_wdata[PP])) |=> pend[gi]);

    // R3: an event always lands, even against a clear
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[gi] |=> pend[gi]);
  end

  assign irq = |(pend & en);

endmodule

// File: rtl/dma_cs_pos.sv
module dma_cs_pos #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_pend,
  input  logic              take_fault,
  input  logic              take_abort,
  input  logic              take_done,
  input  logic [CNT_W-1:0]  remaining_cnt,
  output logic              ch_stall,
  output logic              ch_retry,
  output logic              ch_advance,
  output logic [CNT_W-1:0]  resume_cnt
);

  logic             fault_prev_q;
  logic             adv_q;
  logic [CNT_W-1:0] resume_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_prev_q <= 1'b0;
      adv_q        <= 1'b0;
      resume_q     <= '0;
    end else begin
      fault_prev_q <= fault_pend;
      adv_q        <= take_abort | take_done;
      if (take_fault) resume_q <= remaining_cnt;
    end
  end

  assign ch_stall   = fault_pend;
  assign ch_retry   = fault_prev_q & ~fault_pend;
  assign ch_advance = adv_q;
  assign resume_cnt = resume_q;

  // R8: a stalled channel never advances
  assert_no_adv_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_stall |-> !ch_advance);

  // R8: the captured count is frozen across a stall
  assert_resume_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_stall |=> $stable(resume_cnt));

  // R9: retry only follows a stall
  assert_retry_after_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ch_retry |-> $past(ch_stall));

endmodule

// File: rtl/dma_cmpl_stat.sv
module dma_cmpl_stat
  import dma_cs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cnt_zero,
  input  logic              periph_done,
  input  logic              desc_irq_done,
  input  logic              bad_desc_ptr,
  input  logic              bad_buf_ptr,
  input  logic              abort_req,
  input  logic [CNT_W-1:0]  remaining_cnt,
  output logic              irq,
  output logic              ch_stall,
  output logic              ch_retry,
  output logic              ch_advance,
  output logic [CNT_W-1:0]  resume_cnt
);

  localparam int LOW_FREE = EN_TOP - NFLAG + 1;

  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] pend;
  logic [NFLAG-1:0] en;
  logic             take_fault;
  logic             take_abort;
  logic             take_done;

  initial begin
    if (CNT_W > LOW_FREE || CNT_W < 1)
      $error("CNT_W must fit below the enable field");
  end

  dma_cs_evt #(.CNT_W(CNT_W)) u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .stalled       (pend[F_FAULT]),
    .norm_en       (en[F_NORM]),
    .cnt_zero      (cnt_zero),
    .periph_done   (periph_done),
    .desc_irq_done (desc_irq_done),
    .bad_desc_ptr  (bad_desc_ptr),
    .bad_buf_ptr   (bad_buf_ptr),
    .abort_req     (abort_req),
    .remaining_cnt (remaining_cnt),
    .take_fault    (take_fault),
    .take_abort    (take_abort),
    .take_done     (take_done),
    .flag_set      (flag_set)
  );

  dma_cs_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_set  (flag_set),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pend      (pend),
    .en        (en),
    .irq       (irq)
  );

  dma_cs_pos #(.CNT_W(CNT_W)) u_pos (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_pend    (pend[F_FAULT]),
    .take_fault    (take_fault),
    .take_abort    (take_abort),
    .take_done     (take_done),
    .remaining_cnt (remaining_cnt),
    .ch_stall      (ch_stall),
    .ch_retry      (ch_retry),
    .ch_advance    (ch_advance),
    .resume_cnt    (resume_cnt)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[CNT_W-1:0] = resume_cnt;
    for (int i = 0; i < NFLAG; i++) begin
      reg_rdata[pend_pos(i)] = pend[i];
      reg_rdata[en_pos(i)]   = en[i];
    end
  end

  // R7: a taken fault stalls the channel on the next cycle
  assert_fault_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> ch_stall);

  // R7: a fault never produces an advance
  assert_fault_no_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> !ch_advance);

endmodule

// File: tb/dma_cmpl_stat_bench.sv
module dma_cmpl_stat_bench;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             cnt_zero = 1'b0;
  logic             periph_done = 1'b0;
  logic             desc_irq_done = 1'b0;
  logic             bad_desc_ptr = 1'b0;
  logic             bad_buf_ptr = 1'b0;
  logic             abort_req = 1'b0;
  logic [CNT_W-1:0] remaining_cnt = '0;
  logic             irq;
  logic             ch_stall;
  logic             ch_retry;
  logic             ch_advance;
  logic [CNT_W-1:0] resume_cnt;

  int    n_checks = 0;
  int    n_errors = 0;
  int    n_cycles = 0;
  bit    done_flag = 0;
  string cur_req = "R1";

  // reference model state
  bit m_norm, m_fault, m_abort, m_prem;
  bit e_norm, e_fault, e_abort, e_prem;
  int m_resume;
  bit m_adv, m_retry;

  always #2.5 clk = ~clk;

  dma_cmpl_stat #(.CNT_W(CNT_W)) u_dma_cmpl_stat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_zero(cnt_zero), .periph_done(periph_done),
    .desc_irq_done(desc_irq_done), .bad_desc_ptr(bad_desc_ptr),
    .bad_buf_ptr(bad_buf_ptr), .abort_req(abort_req),
    .remaining_cnt(remaining_cnt), .irq(irq), .ch_stall(ch_stall),
    .ch_retry(ch_retry), .ch_advance(ch_advance), .resume_cnt(resume_cnt)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", cur_req, what, act, exp, n_cycles);
    end
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[31] = m_norm;  w[30] = m_fault; w[28] = m_abort; w[27] = m_prem;
    w[25] = e_norm;  w[24] = e_fault; w[23] = e_abort; w[22] = e_prem;
    w[15:0] = m_resume[15:0];
    return w;
  endfunction

  task automatic model_reset();
    {m_norm, m_fault, m_abort, m_prem} = '0;
    {e_norm, e_fault, e_abort, e_prem} = '0;
    m_resume = 0; m_adv = 0; m_retry = 0;
  endtask

  // behavioural restatement of the requirements, evaluated per clock
  task automatic model_step();
    bit s_norm = 0, s_fault = 0, s_abort = 0, s_prem = 0;
    bit was_fault = m_fault;
    m_adv = 0;
    if (!m_fault) begin
      if (bad_desc_ptr || bad_buf_ptr) begin
        s_fault = 1; m_resume = int'(remaining_cnt);
      end else if (abort_req) begin
        s_abort = 1; m_adv = 1;
      end else if (cnt_zero || periph_done) begin
        m_adv = 1;
        if (e_norm || desc_irq_done) s_norm = 1;
        if (periph_done && !cnt_zero && remaining_cnt != 0) s_prem = 1;
      end
    end
    if (reg_wr) begin
      if (reg_wdata[31]) m_norm = 0;
      if (reg_wdata[30]) m_fault = 0;
      if (reg_wdata[28]) m_abort = 0;
      if (reg_wdata[27]) m_prem = 0;
      e_norm = reg_wdata[25]; e_fault = reg_wdata[24];
      e_abort = reg_wdata[23]; e_prem = reg_wdata[22];
    end
    m_norm |= s_norm; m_fault |= s_fault; m_abort |= s_abort; m_prem |= s_prem;
    m_retry = was_fault && !m_fault;
  endtask

  task automatic compare_all();
    bit exp_irq = (m_norm & e_norm) | (m_fault & e_fault) | (m_abort & e_abort) | (m_prem & e_prem);
    check("rdata",   reg_rdata, model_word());
    check("irq",     {31'b0, irq}, {31'b0, exp_irq});
    check("stall",   {31'b0, ch_stall}, {31'b0, m_fault});
    check("retry",   {31'b0, ch_retry}, {31'b0, m_retry});
    check("advance", {31'b0, ch_advance}, {31'b0, m_adv});
    check("resume",  {16'b0, resume_cnt}, m_resume[31:0]);
  endtask

  task automatic idle_inputs();
    reg_wr = 0; reg_wdata = '0; cnt_zero = 0; periph_done = 0; desc_irq_done = 0;
    bad_desc_ptr = 0; bad_buf_ptr = 0; abort_req = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    n_cycles++;
    model_step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; cyc();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst_n = 1;
    cyc(); cyc();

    cur_req = "R2";                       // enables only
    wr(32'h03C0_0000);
    wr(32'h0000_0000);

    cur_req = "R5";                       // completion, no flag wanted
    cnt_zero = 1; remaining_cnt = 0; cyc();
    cyc();
    desc_irq_done = 1; cnt_zero = 1; cyc();   // descriptor mark sets normal flag
    cyc();

    cur_req = "R4";
    wr(32'h0200_0000);                     // normal enable, irq rises
    cyc();

    cur_req = "R2";
    wr(32'h0200_0000);                     // write 0 at bit 31: flag stays
    wr(32'h8200_0000);                     // clear normal flag

    cur_req = "R6";
    periph_done = 1; remaining_cnt = 16'd5; cyc();
    periph_done = 1; cnt_zero = 1; remaining_cnt = 16'd9; cyc();   // not premature

    cur_req = "R3";
    reg_wr = 1; reg_wdata = 32'h0840_0000; periph_done = 1; remaining_cnt = 16'd3; cyc();
    wr(32'h0840_0000);

    cur_req = "R10";
    wr(32'h0380_0000);
    abort_req = 1; desc_irq_done = 1; cyc();
    cyc();

    cur_req = "R7";
    bad_buf_ptr = 1; remaining_cnt = 16'h1234; cyc();
    cyc();

    cur_req = "R8";
    cnt_zero = 1; cyc();
    abort_req = 1; cyc();
    bad_desc_ptr = 1; remaining_cnt = 16'h0055; cyc();
    periph_done = 1; remaining_cnt = 16'h0007; cyc();

    cur_req = "R9";
    wr(32'h4380_0000);
    cyc();

    cur_req = "R11";
    bad_desc_ptr = 1; abort_req = 1; cnt_zero = 1; remaining_cnt = 16'h0abc; cyc();
    wr(32'h5F80_0000);
    abort_req = 1; periph_done = 1; remaining_cnt = 16'h0011; cyc();
    cyc();

    cur_req = "R11 random";
    for (int k = 0; k < 600; k++) begin
      bad_desc_ptr  = ($urandom_range(0, 39) == 0);
      bad_buf_ptr   = ($urandom_range(0, 39) == 0);
      abort_req     = ($urandom_range(0, 14) == 0);
      cnt_zero      = ($urandom_range(0, 5) == 0);
      periph_done   = ($urandom_range(0, 5) == 0);
      desc_irq_done = ($urandom_range(0, 1) == 0);
      remaining_cnt = ($urandom_range(0, 3) == 0) ? '0 : CNT_W'($urandom);
      reg_wr        = ($urandom_range(0, 5) == 0);
      reg_wdata     = $urandom;
      cyc();
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule